// File: doc/BRIEF.md
# Configurable GPIO Function Controller

This block owns one general-purpose pin. The pin can replace the serial programming interface for a small set of actions. A configuration word chooses the pin's role. As an input, the pin can trigger a per-channel update, drive a per-channel power-down state, or act as an active-low device reset. As an output, it shows one of the internal status bits.

At power-up, the block waits for a boot-done strobe. On the first strobe it reads the pin's synchronised level and executes the mapped command once, which sets the initial channel state. After that, input functions act only on edges of the pin. While an input function is mapped, the block raises a block-mask for the matching software trigger bits. The register logic elsewhere uses this mask to ignore those bits, so the pin and software never race.

The pin input passes through a synchroniser chain before edge detection. Every command leaves as a registered pulse that lasts one clock.

Top module: `gpiofn_ctrl`

## Requirements
- R1: With `cfg_out_en`=1 and `cfg_in_en`=0, a function code 8+k (bit 3 set, k in bits 2:0) with k < NSTAT sets `pin_oe`=1 and `pin_o`=`status_i[k]`, one clock after sampling. Any other code in this mode gives `pin_oe`=0 and `pin_o`=0.
- R2: When both enable bits are set, the input role wins and `pin_oe` is 0.
- R3: Function code 0 (the reset default) maps nothing: no command pulse, no reset request, no output drive and no block-mask.
- R4: On the first `boot_done` strobe after reset, the synchronised pin level is executed once. Code 1 (update) with the level low pulses `upd_pulse`. Code 2 (power-down) with the level high pulses `pdn_set`, and with the level low pulses `pdn_clr`. All pulses go to the channels in `cfg_ch_mask`. Later strobes have no effect.
- R5: Before boot, pin activity produces no command or reset request. After boot, a held level produces no repeated command.
- R6: With code 1 and the input role selected, each falling edge of the pin gives a one-clock `upd_pulse` equal to `cfg_ch_mask`. Rising edges give nothing.
- R7: With code 2 and the input role selected, a rising edge gives a one-clock `pdn_set` equal to `cfg_ch_mask`. A falling edge gives a one-clock `pdn_clr` equal to `cfg_ch_mask`. The two never fire together.
- R8: With the input role selected, `sw_upd_blk` equals `cfg_ch_mask` for code 1, and `sw_pdn_blk` equals `cfg_ch_mask` for code 2. `sw_rst_blk` is 1 for code 3. All three are 0 otherwise.
- R9: With code 3 and the input role selected, a low pulse that starts after boot raises `reset_req` for exactly one clock after the pin returns high. A falling edge alone raises nothing.
- R10: Suppose a pin change is present at clock edge n. The resulting command is visible in the cycle after edge n+2: two synchroniser flops, then the output register.
- R11: Synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in_en | input | 1 | Selects the input role |
| cfg_out_en | input | 1 | Selects the output role |
| cfg_func | input | 4 | Function code |
| cfg_ch_mask | input | NCH | Channels targeted by per-channel functions |
| pin_i | input | 1 | Raw pin level, asynchronous |
| boot_done | input | 1 | Boot-complete strobe |
| status_i | input | NSTAT | Internal status bits for output mode |
| upd_pulse | output | NCH | Per-channel update command pulse |
| pdn_set | output | NCH | Per-channel power-down enter pulse |
| pdn_clr | output | NCH | Per-channel power-down exit pulse |
| reset_req | output | 1 | Device reset request pulse |
| pin_o | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output driver enable |
| sw_upd_blk | output | NCH | Software update bits to ignore |
| sw_pdn_blk | output | NCH | Software power-down bits to ignore |
| sw_rst_blk | output | 1 | Software reset bit to ignore |

## Verification
The main input path is tried in several ways:
- A pin toggled before boot separates edge handling from level capture.
- A low level and a high level at boot tell the update capture from the power-down capture.
- Single falling and rising edges after boot show which edge polarity each function honours.
- A long hold proves that a level does not repeat a command.

For the reset function, a low pulse is split into its falling and rising halves, which shows that the request waits for the end of the pulse. In output mode, status toggles confirm the selection. An out-of-range code and both enables set confirm that the driver stays off.

// File: rtl/gpiofn_pkg.sv
package gpiofn_pkg;
  localparam int FUNC_W   = 4;
  localparam int IDX_W    = FUNC_W - 1;
  localparam int STAT_MAX = 1 << IDX_W;

  typedef enum logic [FUNC_W-1:0] {
    FN_NONE = 4'd0,
    FN_UPD  = 4'd1,
    FN_PDN  = 4'd2,
    FN_RST  = 4'd3
  } in_fn_e;

  function automatic logic fn_is(input logic [FUNC_W-1:0] f, input in_fn_e k);
    return f == k;
  endfunction
endpackage

// File: rtl/gpiofn_sync.sv
module gpiofn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpiofn_edge.sv
module gpiofn_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/gpiofn_infn.sv
module gpiofn_infn
  import gpiofn_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_en,
  input  logic [FUNC_W-1:0] func,
  input  logic [NCH-1:0]    mask,
  input  logic              lvl,
  input  logic              rise,
  input  logic              fall,
  input  logic              boot_done,
  output logic [NCH-1:0]    upd,
  output logic [NCH-1:0]    pset,
  output logic [NCH-1:0]    pclr,
  output logic              req,
  output logic [NCH-1:0]    upd_blk,
  output logic [NCH-1:0]    pdn_blk,
  output logic              rst_blk
);
  logic booted, armed, armed_n;
  logic fn_upd, fn_pdn, fn_rst;
  logic [NCH-1:0] upd_n, set_n, clr_n;
  logic req_n;

  assign fn_upd = in_en & fn_is(func, FN_UPD);
  assign fn_pdn = in_en & fn_is(func, FN_PDN);
  assign fn_rst = in_en & fn_is(func, FN_RST);

  always_comb begin
    upd_n   = '0;
    set_n   = '0;
    clr_n   = '0;
    req_n   = 1'b0;
    armed_n = armed;
    if (!booted) begin
      if (boot_done) begin
        if (fn_upd && !lvl) upd_n = mask;
        if (fn_pdn) begin
          if (lvl) set_n = mask;
          else     clr_n = mask;
        end
      end
    end else begin
      if (fn_upd && fall) upd_n = mask;
      if (fn_pdn && rise) set_n = mask;
      if (fn_pdn && fall) clr_n = mask;
      if (fn_rst) begin
        if (rise && armed) begin
          req_n   = 1'b1;
          armed_n = 1'b0;
        end else if (fall) begin
          armed_n = 1'b1;
        end
      end
    end
    if (!fn_rst) armed_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      booted  <= 1'b0;
      armed   <= 1'b0;
      upd     <= '0;
      pset    <= '0;
      pclr    <= '0;
      req     <= 1'b0;
      upd_blk <= '0;
      pdn_blk <= '0;
      rst_blk <= 1'b0;
    end else begin
      booted  <= booted | boot_done;
      armed   <= armed_n;
      upd     <= upd_n;
      pset    <= set_n;
      pclr    <= clr_n;
      req     <= req_n;
      upd_blk <= fn_upd ? mask : '0;
      pdn_blk <= fn_pdn ? mask : '0;
      rst_blk <= fn_rst;
    end
  end
endmodule

// File: rtl/gpiofn_outfn.sv
module gpiofn_outfn
  import gpiofn_pkg::*;
#(
  parameter int NSTAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_en,
  input  logic              out_en,
  input  logic [FUNC_W-1:0] func,
  input  logic [NSTAT-1:0]  status,
  output logic              pin_o,
  output logic              pin_oe
);
  logic [IDX_W-1:0]    idx;
  logic [STAT_MAX-1:0] stat_pad;
  logic                drive;

  assign idx      = func[IDX_W-1:0];
  assign stat_pad = STAT_MAX'(status);
  assign drive    = out_en & ~in_en & func[FUNC_W-1] & (int'(idx) < NSTAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o  <= 1'b0;
      pin_oe <= 1'b0;
    end else begin
      pin_oe <= drive;
      pin_o  <= drive & stat_pad[idx];
    end
  end
endmodule

// File: rtl/gpiofn_ctrl.sv
module gpiofn_ctrl
  import gpiofn_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int NSTAT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_in_en,
  input  logic              cfg_out_en,
  input  logic [FUNC_W-1:0] cfg_func,
  input  logic [NCH-1:0]    cfg_ch_mask,
  input  logic              pin_i,
  input  logic              boot_done,
  input  logic [NSTAT-1:0]  status_i,
  output logic [NCH-1:0]    upd_pulse,
  output logic [NCH-1:0]    pdn_set,
  output logic [NCH-1:0]    pdn_clr,
  output logic              reset_req,
  output logic              pin_o,
  output logic              pin_oe,
  output logic [NCH-1:0]    sw_upd_blk,
  output logic [NCH-1:0]    sw_pdn_blk,
  output logic              sw_rst_blk
);
  logic pin_s, pin_rise, pin_fall;

  gpiofn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_i),
    .q   (pin_s)
  );

  gpiofn_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pin_s),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  gpiofn_infn #(.NCH(NCH)) u_in (
    .clk       (clk),
    .rst       (rst),
    .in_en     (cfg_in_en),
    .func      (cfg_func),
    .mask      (cfg_ch_mask),
    .lvl       (pin_s),
    .rise      (pin_rise),
    .fall      (pin_fall),
    .boot_done (boot_done),
    .upd       (upd_pulse),
    .pset      (pdn_set),
    .pclr      (pdn_clr),
    .req       (reset_req),
    .upd_blk   (sw_upd_blk),
    .pdn_blk   (sw_pdn_blk),
    .rst_blk   (sw_rst_blk)
  );

  gpiofn_outfn #(.NSTAT(NSTAT)) u_out (
    .clk    (clk),
    .rst    (rst),
    .in_en  (cfg_in_en),
    .out_en (cfg_out_en),
    .func   (cfg_func),
    .status (status_i),
    .pin_o  (pin_o),
    .pin_oe (pin_oe)
  );
endmodule

// File: rtl/gpiofn_ctrl_chk.sv
module gpiofn_ctrl_chk
  import gpiofn_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NSTAT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_in_en,
  input logic              cfg_out_en,
  input logic [FUNC_W-1:0] cfg_func,
  input logic [NCH-1:0]    cfg_ch_mask,
  input logic              boot_done,
  input logic [NSTAT-1:0]  status_i,
  input logic [NCH-1:0]    upd_pulse,
  input logic [NCH-1:0]    pdn_set,
  input logic [NCH-1:0]    pdn_clr,
  input logic              reset_req,
  input logic              pin_o,
  input logic              pin_oe,
  input logic [NCH-1:0]    sw_upd_blk,
  input logic [NCH-1:0]    sw_pdn_blk,
  input logic              sw_rst_blk
);
  logic seen_boot;

  always_ff @(posedge clk) begin
    if (rst)            seen_boot <= 1'b0;
    else if (boot_done) seen_boot <= 1'b1;
  end

  AST_OUT_SELECT: assert property (@(posedge clk) disable iff (rst)
    (cfg_out_en && !cfg_in_en && cfg_func == FUNC_W'(8)) |=> (pin_oe && pin_o == $past(status_i[0]))); // R1
  AST_INPUT_WINS: assert property (@(posedge clk) disable iff (rst)
    cfg_in_en |=> !pin_oe); // R2
  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cfg_func == '0) |=> (upd_pulse == '0 && pdn_set == '0 && pdn_clr == '0 && !reset_req && !pin_oe)); // R3
  AST_PREBOOT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !seen_boot |-> (upd_pulse == '0 && pdn_set == '0 && pdn_clr == '0 && !reset_req)); // R5
  AST_UPD_IN_MASK: assert property (@(posedge clk) disable iff (rst)
    (upd_pulse != '0) |-> ((upd_pulse & ~$past(cfg_ch_mask)) == '0)); // R6
  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
    (pdn_set & pdn_clr) == '0); // R7
  AST_BLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cfg_in_en |=> (sw_upd_blk == '0 && sw_pdn_blk == '0 && !sw_rst_blk)); // R8
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req); // R9
endmodule

bind gpiofn_ctrl gpiofn_ctrl_chk #(.NCH(NCH), .NSTAT(NSTAT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_in_en   (cfg_in_en),
  .cfg_out_en  (cfg_out_en),
  .cfg_func    (cfg_func),
  .cfg_ch_mask (cfg_ch_mask),
  .boot_done   (boot_done),
  .status_i    (status_i),
  .upd_pulse   (upd_pulse),
  .pdn_set     (pdn_set),
  .pdn_clr     (pdn_clr),
  .reset_req   (reset_req),
  .pin_o       (pin_o),
  .pin_oe      (pin_oe),
  .sw_upd_blk  (sw_upd_blk),
  .sw_pdn_blk  (sw_pdn_blk),
  .sw_rst_blk  (sw_rst_blk)
);

// File: tb/gpiofn_ctrl_test.sv
module gpiofn_ctrl_test;
  localparam int NCH = 4;
  localparam int NSTAT = 4;

  logic clk = 1'b0;
  logic rst, in_en, out_en, pin, boot;
  logic [3:0] func;
  logic [NCH-1:0] mask;
  logic [NSTAT-1:0] stat;
  logic [NCH-1:0] upd, pset, pclr, ublk, pblk;
  logic req, po, poe, rblk;

  gpiofn_ctrl #(.NCH(NCH), .NSTAT(NSTAT)) uut (
    .clk(clk), .rst(rst), .cfg_in_en(in_en), .cfg_out_en(out_en), .cfg_func(func),
    .cfg_ch_mask(mask), .pin_i(pin), .boot_done(boot), .status_i(stat),
    .upd_pulse(upd), .pdn_set(pset), .pdn_clr(pclr), .reset_req(req),
    .pin_o(po), .pin_oe(poe), .sw_upd_blk(ublk), .sw_pdn_blk(pblk), .sw_rst_blk(rblk)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int upd_cnt = 0, set_cnt = 0, clr_cnt = 0, req_cnt = 0;
  string tag = "R11";
  bit started = 0, done = 0;

  // behavioural reference model
  bit q[$];
  bit m_boot, m_arm;
  logic [NCH-1:0] e_upd, e_set, e_clr, e_ublk, e_pblk;
  logic e_req, e_o, e_oe, e_rblk;

  always @(posedge clk) begin
    if (rst) begin
      q = {1'b0, 1'b0, 1'b0};
      m_boot = 0; m_arm = 0;
      e_upd = '0; e_set = '0; e_clr = '0; e_ublk = '0; e_pblk = '0;
      e_req = 0; e_o = 0; e_oe = 0; e_rblk = 0;
    end else begin
      bit lv, pv, ri, fa;
      lv = q[q.size()-2];
      pv = q[q.size()-3];
      ri = lv && !pv;
      fa = !lv && pv;
      e_oe = out_en && !in_en && func[3] && (func[2:0] < NSTAT);
      e_o = e_oe ? stat[func[1:0]] : 1'b0;
      e_ublk = (in_en && func == 1) ? mask : '0;
      e_pblk = (in_en && func == 2) ? mask : '0;
      e_rblk = in_en && func == 3;
      e_upd = '0; e_set = '0; e_clr = '0; e_req = 0;
      if (in_en) begin
        if (!m_boot) begin
          if (boot) begin
            if (func == 1 && !lv) e_upd = mask;
            if (func == 2) begin
              if (lv) e_set = mask; else e_clr = mask;
            end
          end
        end else begin
          if (func == 1 && fa) e_upd = mask;
          if (func == 2 && ri) e_set = mask;
          if (func == 2 && fa) e_clr = mask;
          if (func == 3) begin
            if (ri && m_arm) begin e_req = 1; m_arm = 0; end
            else if (fa) m_arm = 1;
          end
        end
      end
      if (!(in_en && func == 3)) m_arm = 0;
      if (boot) m_boot = 1;
      q.push_back(pin);
      if (q.size() > 3) void'(q.pop_front());
    end
  end

  task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check(tag, 64'({upd, pset, pclr, req, po, poe, ublk, pblk, rblk}),
                 64'({e_upd, e_set, e_clr, e_req, e_o, e_oe, e_ublk, e_pblk, e_rblk}));
      if (upd != 0) upd_cnt++;
      if (pset != 0) set_cnt++;
      if (pclr != 0) clr_cnt++;
      if (req) req_cnt++;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_reset;
    rst = 1; boot = 0; tick(2); rst = 0;
  endtask

  task automatic boot_pulse;
    boot = 1; tick(1); boot = 0;
  endtask

  initial begin
    int c0, c1;
    rst = 1; in_en = 0; out_en = 0; func = 0; mask = 0; pin = 0; boot = 0; stat = 0;
    @(posedge clk); started = 1;
    tick(3);
    check("R11 reset state", 64'({upd, pset, pclr, req, po, poe, ublk, pblk, rblk}), 64'd0);
    rst = 0;

    // R3: nothing mapped
    tag = "R3"; in_en = 1; mask = 4'hF; c0 = upd_cnt + set_cnt + clr_cnt + req_cnt;
    pin = 1; tick(4); boot_pulse(); tick(2); pin = 0; tick(4); pin = 1; tick(4);
    check("R3 no commands", upd_cnt + set_cnt + clr_cnt + req_cnt - c0, 0);
    check("R3 no drive/mask", 64'({poe, ublk, pblk, rblk}), 64'd0);

    // R5/R6/R10: update function, edges before and after boot
    tag = "R6"; do_reset(); func = 1; mask = 4'b0101; pin = 1; tick(4);
    c0 = upd_cnt;
    pin = 0; tick(4); pin = 1; tick(4); pin = 0; tick(4); pin = 1; tick(4);
    check("R5 no pre-boot update", upd_cnt - c0, 0);
    boot_pulse(); tick(2);
    check("R4 high level gives no update", upd_cnt - c0, 0);
    pin = 0;
    @(negedge clk); @(negedge clk); #1;
    check("R10 not yet at edge n+1", 64'(upd), 64'd0);
    @(negedge clk); #1;
    check("R10 R6 update after edge n+2", 64'(upd), 64'(4'b0101));
    @(negedge clk); #1;
    check("R6 update lasts one clock", 64'(upd), 64'd0);
    tick(10);
    check("R5 held low gives one update", upd_cnt - c0, 1);
    pin = 1; tick(6);
    check("R6 rising edge ignored", upd_cnt - c0, 1);

    // R7/R4: power-down function
    tag = "R7"; do_reset(); func = 2; mask = 4'b1010; pin = 1; tick(4);
    c0 = set_cnt; c1 = clr_cnt;
    boot_pulse(); tick(2);
    check("R4 high level sets power-down", set_cnt - c0, 1);
    pin = 0; tick(5);
    check("R7 falling edge clears", clr_cnt - c1, 1);
    pin = 1; tick(5);
    check("R7 rising edge sets", set_cnt - c0, 2);
    tick(10);
    check("R5 held high no repeat", set_cnt - c0 + clr_cnt - c1, 3);

    // R4: update captured with pin low, later strobe ignored
    tag = "R4"; do_reset(); func = 1; mask = 4'b0011; pin = 0; tick(4);
    c0 = upd_cnt;
    boot_pulse(); tick(2);
    check("R4 low level updates once", upd_cnt - c0, 1);
    boot_pulse(); tick(3);
    check("R4 second strobe ignored", upd_cnt - c0, 1);

    // R9: reset pulse
    tag = "R9"; do_reset(); func = 3; pin = 1; tick(4);
    c0 = req_cnt;
    pin = 0; tick(5); pin = 1; tick(5);
    check("R9 pre-boot pulse ignored", req_cnt - c0, 0);
    boot_pulse(); tick(2);
    check("R8 reset block bit", 64'(rblk), 64'd1);
    pin = 0; tick(6);
    check("R9 falling edge alone", req_cnt - c0, 0);
    pin = 1; tick(4);
    check("R9 request after release", req_cnt - c0, 1);
    tick(6);
    check("R9 single request", req_cnt - c0, 1);

    // R1/R2: output role
    tag = "R1"; in_en = 0; out_en = 1; func = 4'hA; stat = 4'b0100; tick(2);
    check("R1 drives status bit 2", 64'({poe, po}), 64'(2'b11));
    stat = 4'b1011; tick(2);
    check("R1 follows status", 64'({poe, po}), 64'(2'b10));
    func = 4'hF; tick(2);
    check("R1 out-of-range code", 64'({poe, po}), 64'd0);
    tag = "R2"; func = 4'h9; in_en = 1; tick(2);
    check("R2 input wins", 64'(poe), 64'd0);

    // R8: block masks
    tag = "R8"; out_en = 0; func = 1; mask = 4'b0110; tick(2);
    check("R8 update mask", 64'({ublk, pblk}), 64'({4'b0110, 4'b0000}));
    func = 2; tick(2);
    check("R8 power-down mask", 64'({ublk, pblk}), 64'({4'b0000, 4'b0110}));
    in_en = 0; tick(2);
    check("R8 masks cleared", 64'({ublk, pblk, rblk}), 64'd0);

    tag = "R11"; do_reset(); tick(1);
    check("R11 reset clears", 64'({upd, pset, pclr, req, po, poe, ublk, pblk, rblk}), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule